// File: doc/BRIEF.md
# Audio Bit and Frame Clock Generator

The block runs on the master audio clock. It produces the serial bit clock and two frame (left/right) clocks, one for transmit and one for receive, for the serializers of an audio port. In master mode, a bit-clock divider counts master-clock cycles. Its wrap pulse advances two frame dividers, and each frame divider toggles its frame clock after half a frame. In slave mode, the dividers sit idle. The block then samples externally supplied bit and frame clocks through a two-flop synchronizer and presents them on the same outputs.

All outputs come from registers. A one-cycle rise pulse and a one-cycle fall pulse accompany the bit clock output. A one-cycle change pulse accompanies each frame clock. The serializers use these pulses as clock enables in the master-clock domain.

A polarity control inverts the bit clock, which moves frame-clock changes from the falling to the rising bit-clock edge. A sharing control makes the receive side use the transmit frame clock.

New divider values are taken only at frame boundaries, so a clock pulse is never cut short.

Top module: `audio_clk_gen`

## Requirements
- R1: While `rst_ni` is low, every output is 0. After reset the block runs with the default divider values: bit divider value 3 (4 master clocks per bit) and frame divider value 63 (64 bits per frame) on both sides. These defaults hold until the first frame boundary.
- R2: In master mode the bit period is N = D+1 master clocks, where D is the latched bit divider value and a value of 0 is taken as 1. With normal polarity the bit clock is low for floor(N/2) cycles and then high for the rest of the period.
- R3: In master mode each frame clock has a period of F = E+1 bit periods, where E is the latched frame divider value and a value of 0 is taken as 1. The frame clock is low for floor(F/2) bit periods and then high for the rest. A frame boundary is the high-to-low change of the frame clock.
- R4: With the sharing field at 0, the transmit and receive frame clocks follow their own divider fields independently of each other.
- R5: With the sharing field non-zero, the receive frame clock output equals the transmit frame clock output, in both modes.
- R6: A new bit divider value or transmit frame divider value takes effect only at a transmit frame boundary. A new receive frame divider value takes effect only at a receive frame boundary. Writing a new value mid-frame leaves the current bit period unchanged.
- R7: In master mode, with normal polarity, every frame clock change falls in the same cycle as the bit clock fall pulse. With the polarity bit set, the bit clock output is inverted and every frame clock change falls in the same cycle as the rise pulse.
- R8: The rise pulse is high for exactly the one cycle in which the bit clock output has just gone from 0 to 1, and the fall pulse likewise for 1 to 0. Each frame change pulse is high for the one cycle after either change of its frame clock.
- R9: In slave mode (`slave_i`=1), each clock output equals its external input from 3 master-clock cycles earlier: two synchronizer stages plus the output register. The bit clock is inverted when the polarity bit is set, and the polarity bit has no effect on the frame clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | master audio clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| slave_i | input | 1 | 0: generate clocks, 1: follow external clocks |
| bclk_inv_i | input | 1 | invert the bit clock |
| share_i | input | 2 | 0: independent frame clocks, non-zero: receive uses transmit |
| mdiv_i | input | 8 | master clocks per bit, minus one |
| tx_fdiv_i | input | 8 | bits per transmit frame, minus one |
| rx_fdiv_i | input | 8 | bits per receive frame, minus one |
| bclk_i | input | 1 | external bit clock (slave mode) |
| tx_fclk_i | input | 1 | external transmit frame clock (slave mode) |
| rx_fclk_i | input | 1 | external receive frame clock (slave mode) |
| bclk_o | output | 1 | bit clock |
| bclk_rise_o | output | 1 | one-cycle pulse after bit clock rises |
| bclk_fall_o | output | 1 | one-cycle pulse after bit clock falls |
| tx_fclk_o | output | 1 | transmit frame clock |
| tx_fedge_o | output | 1 | one-cycle pulse after transmit frame clock changes |
| rx_fclk_o | output | 1 | receive frame clock |
| rx_fedge_o | output | 1 | one-cycle pulse after receive frame clock changes |

## Verification
The hardest case to reach is a divider value written in the middle of a frame. The bench must show that the old bit period survives until the exact boundary and that the new one starts right after it. To get there, the bench waits for the transmit frame clock's rising change, which falls mid-frame, and writes a new bit divider value there. It then measures one bit period, which must still be the old one. Next it waits for the falling frame change and measures again, expecting the new period and its odd-ratio duty. Slave-mode latency is checked cycle by cycle against a history of the driven inputs, which pins both the synchronizer depth and the exact cycle of each edge pulse.

// File: rtl/acd_pkg.sv
package acd_pkg;
  parameter int unsigned DIV_W = 8;
  typedef logic [DIV_W-1:0] div_t;

  // a divider of zero would stall the clock; treat it as one
  function automatic div_t clamp1(input div_t v);
    return (v == '0) ? div_t'(1) : v;
  endfunction
endpackage

// File: rtl/acd_sync.sv
module acd_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      q_o  <= '0;
    end else begin
      s1_q <= d_i;
      q_o  <= s1_q;
    end
  end
endmodule

// File: rtl/acd_bit_div.sv
module acd_bit_div import acd_pkg::*; #(
  parameter div_t RST_DIV = div_t'(3)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic load_i,
  input  div_t div_i,
  output logic raw_o,
  output logic wrap_o
);
  div_t act_q, cnt_q;
  logic [DIV_W:0] period;

  assign period = {1'b0, act_q} + 1'b1;
  assign wrap_o = run_i && (cnt_q == act_q);
  assign raw_o  = {1'b0, cnt_q} >= (period >> 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= RST_DIV;
    end else begin
      if (!run_i || wrap_o) cnt_q <= '0;
      else                  cnt_q <= div_t'(cnt_q + 1'b1);
      if (load_i) act_q <= clamp1(div_i);
    end
  end

  // R2
  bit_cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= act_q);

  // R6
  bit_div_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q != $past(act_q)) |-> $past(load_i));
endmodule

// File: rtl/acd_frame_div.sv
module acd_frame_div import acd_pkg::*; #(
  parameter div_t RST_DIV = div_t'(63)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic adv_i,
  input  div_t div_i,
  output logic raw_o,
  output logic wrap_o
);
  div_t act_q, cnt_q;
  logic [DIV_W:0] period;

  assign period = {1'b0, act_q} + 1'b1;
  assign wrap_o = run_i && adv_i && (cnt_q == act_q);
  assign raw_o  = {1'b0, cnt_q} >= (period >> 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      act_q <= RST_DIV;
    end else if (!run_i) begin
      cnt_q <= '0;
    end else if (wrap_o) begin
      cnt_q <= '0;
      act_q <= clamp1(div_i);
    end else if (adv_i) begin
      cnt_q <= div_t'(cnt_q + 1'b1);
    end
  end

  // R3
  frame_cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= act_q);

  // R6
  frame_div_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q != $past(act_q)) |-> $past(wrap_o));
endmodule

// File: rtl/audio_clk_gen.sv
module audio_clk_gen import acd_pkg::*; #(
  parameter div_t RST_MDIV    = div_t'(3),
  parameter div_t RST_TX_FDIV = div_t'(63),
  parameter div_t RST_RX_FDIV = div_t'(63)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             slave_i,
  input  logic             bclk_inv_i,
  input  logic [1:0]       share_i,
  input  logic [DIV_W-1:0] mdiv_i,
  input  logic [DIV_W-1:0] tx_fdiv_i,
  input  logic [DIV_W-1:0] rx_fdiv_i,
  input  logic             bclk_i,
  input  logic             tx_fclk_i,
  input  logic             rx_fclk_i,
  output logic             bclk_o,
  output logic             bclk_rise_o,
  output logic             bclk_fall_o,
  output logic             tx_fclk_o,
  output logic             tx_fedge_o,
  output logic             rx_fclk_o,
  output logic             rx_fedge_o
);
  // lane 0: bit clock, lane 1: tx frame, lane 2: rx frame
  localparam int unsigned LANES = 3;

  logic [LANES-1:0] ext_sync, src, pin_q, pin_d, rise, fall;
  logic bit_raw, bit_wrap, tx_raw, tx_wrap, rx_raw, rx_wrap;

  acd_sync #(.W(LANES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({rx_fclk_i, tx_fclk_i, bclk_i}),
    .q_o   (ext_sync)
  );

  acd_bit_div #(.RST_DIV(RST_MDIV)) u_bit (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (!slave_i),
    .load_i(tx_wrap),
    .div_i (mdiv_i),
    .raw_o (bit_raw),
    .wrap_o(bit_wrap)
  );

  acd_frame_div #(.RST_DIV(RST_TX_FDIV)) u_tx (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (!slave_i),
    .adv_i (bit_wrap),
    .div_i (tx_fdiv_i),
    .raw_o (tx_raw),
    .wrap_o(tx_wrap)
  );

  acd_frame_div #(.RST_DIV(RST_RX_FDIV)) u_rx (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (!slave_i),
    .adv_i (bit_wrap),
    .div_i (rx_fdiv_i),
    .raw_o (rx_raw),
    .wrap_o(rx_wrap)
  );

  always_comb begin
    src[0] = (slave_i ? ext_sync[0] : bit_raw) ^ bclk_inv_i;
    src[1] = slave_i ? ext_sync[1] : tx_raw;
    src[2] = (share_i != 2'd0) ? src[1] : (slave_i ? ext_sync[2] : rx_raw);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q <= '0;
      pin_d <= '0;
    end else begin
      pin_q <= src;
      pin_d <= pin_q;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_edge
    assign rise[g] = pin_q[g] & ~pin_d[g];
    assign fall[g] = ~pin_q[g] & pin_d[g];
  end

  assign bclk_o      = pin_q[0];
  assign bclk_rise_o = rise[0];
  assign bclk_fall_o = fall[0];
  assign tx_fclk_o   = pin_q[1];
  assign tx_fedge_o  = rise[1] | fall[1];
  assign rx_fclk_o   = pin_q[2];
  assign rx_fedge_o  = rise[2] | fall[2];

  // R6
  rx_wrap_on_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_wrap |-> bit_wrap);

  // R7
  frame_edge_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni, 2) && !$past(slave_i) && !$past(slave_i, 2) &&
     ($past(bclk_inv_i) == $past(bclk_inv_i, 2)) && tx_fedge_o)
    |-> ($past(bclk_inv_i) ? bclk_rise_o : bclk_fall_o));

  // R9
  slave_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni, 3) && $past(slave_i))
    |-> (bclk_o == ($past(bclk_i, 3) ^ $past(bclk_inv_i))));

  // R5
  shared_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && ($past(share_i) != 2'd0)) |-> (rx_fclk_o == tx_fclk_o));
endmodule

// File: tb/audio_clk_gen_tb.sv
module audio_clk_gen_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic slave_i, bclk_inv_i;
  logic [1:0] share_i;
  logic [7:0] mdiv_i, tx_fdiv_i, rx_fdiv_i;
  logic bclk_i, tx_fclk_i, rx_fclk_i;
  logic bclk_o, bclk_rise_o, bclk_fall_o, tx_fclk_o, tx_fedge_o, rx_fclk_o, rx_fedge_o;

  int nchk = 0;
  int nfail = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  audio_clk_gen u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .slave_i(slave_i), .bclk_inv_i(bclk_inv_i),
    .share_i(share_i), .mdiv_i(mdiv_i), .tx_fdiv_i(tx_fdiv_i), .rx_fdiv_i(rx_fdiv_i),
    .bclk_i(bclk_i), .tx_fclk_i(tx_fclk_i), .rx_fclk_i(rx_fclk_i),
    .bclk_o(bclk_o), .bclk_rise_o(bclk_rise_o), .bclk_fall_o(bclk_fall_o),
    .tx_fclk_o(tx_fclk_o), .tx_fedge_o(tx_fedge_o),
    .rx_fclk_o(rx_fclk_o), .rx_fedge_o(rx_fedge_o)
  );

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
  endtask

  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected<=150000", cyc);
      report();
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic sig(input int sel);
    case (sel)
      0:       return bclk_o;
      1:       return tx_fclk_o;
      default: return rx_fclk_o;
    endcase
  endfunction

  // waits for a rise, then counts high and low cycles of one period
  task automatic measure(input int sel, output int hi, output int lo);
    logic prev, cur;
    prev = sig(sel);
    forever begin
      @(negedge clk_i);
      cur = sig(sel);
      if (cur && !prev) break;
      prev = cur;
    end
    hi = 1;
    forever begin
      @(negedge clk_i);
      if (!sig(sel)) break;
      hi++;
    end
    lo = 1;
    forever begin
      @(negedge clk_i);
      if (sig(sel)) break;
      lo++;
    end
  endtask

  task automatic check_period(input string req, input int sel, input int ehi, input int elo);
    int hi, lo;
    measure(sel, hi, lo);
    chk(req, $sformatf("sel%0d high", sel), hi, ehi);
    chk(req, $sformatf("sel%0d low", sel), lo, elo);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic t_reset();
    idle(5);
    chk("R1", "bclk_o in reset", bclk_o, 0);
    chk("R1", "edges in reset", {bclk_rise_o, bclk_fall_o, tx_fedge_o, rx_fedge_o}, 0);
    chk("R1", "frame clocks in reset", {tx_fclk_o, rx_fclk_o}, 0);
    rst_ni = 1'b1;
    check_period("R1", 0, 2, 2);
    check_period("R1", 1, 128, 128);
    check_period("R1", 2, 128, 128);
  endtask

  task automatic t_latch();
    // mid-frame: wait for tx frame clock rising
    do @(negedge clk_i); while (!(tx_fedge_o && tx_fclk_o));
    mdiv_i = 8'd4;
    check_period("R6", 0, 2, 2);
    do @(negedge clk_i); while (!(tx_fedge_o && !tx_fclk_o));
    check_period("R6", 0, 3, 2);
    check_period("R2", 0, 3, 2);
    check_period("R3", 1, 160, 160);
  endtask

  task automatic t_frames();
    tx_fdiv_i = 8'd4;
    rx_fdiv_i = 8'd15;
    mdiv_i    = 8'd3;
    idle(800);
    check_period("R3", 1, 12, 8);
    check_period("R4", 2, 32, 32);
    check_period("R4", 1, 12, 8);
  endtask

  task automatic check_align(input string req, input logic inv, input int n);
    int seen = 0;
    repeat (n) begin
      @(negedge clk_i);
      if (tx_fedge_o) begin
        seen++;
        chk(req, "bit edge at frame change", inv ? bclk_rise_o : bclk_fall_o, 1);
      end
    end
    chk(req, "frame changes seen", (seen > 0) ? 1 : 0, 1);
  endtask

  task automatic t_polarity();
    check_align("R7", 1'b0, 200);
    bclk_inv_i = 1'b1;
    mdiv_i = 8'd4;
    idle(100);
    check_period("R7", 0, 2, 3);
    check_align("R7", 1'b1, 200);
    bclk_inv_i = 1'b0;
    idle(100);
    check_align("R7", 1'b0, 200);
  endtask

  task automatic t_clamp();
    mdiv_i = 8'd0;
    tx_fdiv_i = 8'd0;
    idle(100);
    check_period("R2", 0, 1, 1);
    check_period("R3", 1, 2, 2);
  endtask

  task automatic t_share();
    int bad = 0;
    int edges = 0;
    mdiv_i = 8'd1;
    tx_fdiv_i = 8'd4;
    share_i = 2'd1;
    idle(100);
    repeat (200) begin
      @(negedge clk_i);
      if (rx_fclk_o != tx_fclk_o || rx_fedge_o != tx_fedge_o) bad++;
      if (rx_fedge_o) edges++;
    end
    chk("R5", "shared mismatches", bad, 0);
    chk("R5", "shared edges seen", (edges > 0) ? 1 : 0, 1);
    share_i = 2'd0;
    idle(200);
    check_period("R4", 2, 16, 16);
    check_period("R4", 1, 6, 4);
  endtask

  task automatic t_slave(input logic inv);
    logic db [200];
    logic dt [200];
    logic dr [200];
    int bad_lvl = 0;
    int bad_edge = 0;
    int rises = 0;
    bclk_inv_i = inv;
    slave_i = 1'b1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk_i);
      if (i >= 3) begin
        if (bclk_o != (db[i-3] ^ inv)) bad_lvl++;
        if (tx_fclk_o != dt[i-3]) bad_lvl++;
        if (rx_fclk_o != dr[i-3]) bad_lvl++;
      end
      if (i >= 4) begin
        if (bclk_rise_o != ((db[i-3] ^ inv) && !(db[i-4] ^ inv))) bad_edge++;
        if (bclk_fall_o != (!(db[i-3] ^ inv) && (db[i-4] ^ inv))) bad_edge++;
        if (tx_fedge_o != (dt[i-3] != dt[i-4])) bad_edge++;
        if (bclk_rise_o) rises++;
      end
      db[i] = ((i / 3) % 2) == 1;
      dt[i] = ((i / 24) % 2) == 1;
      dr[i] = ((i / 16) % 2) == 1;
      bclk_i = db[i];
      tx_fclk_i = dt[i];
      rx_fclk_i = dr[i];
    end
    chk("R9", $sformatf("slave level mismatches inv=%0d", inv), bad_lvl, 0);
    chk("R8", $sformatf("slave edge pulse mismatches inv=%0d", inv), bad_edge, 0);
    chk("R8", "slave rise pulses seen", (rises > 20) ? 1 : 0, 1);
    slave_i = 1'b0;
    bclk_i = 1'b0;
    tx_fclk_i = 1'b0;
    rx_fclk_i = 1'b0;
  endtask

  initial begin
    slave_i = 1'b0; bclk_inv_i = 1'b0; share_i = 2'd0;
    mdiv_i = 8'd3; tx_fdiv_i = 8'd63; rx_fdiv_i = 8'd63;
    bclk_i = 1'b0; tx_fclk_i = 1'b0; rx_fclk_i = 1'b0;
    t_reset();
    t_latch();
    t_frames();
    t_polarity();
    t_clamp();
    t_share();
    t_slave(1'b0);
    t_slave(1'b1);
    done = 1'b1;
    report();
    $finish;
  end
endmodule